// File: doc/BRIEF.md
# DES Round Subkey Generator with Direction Control

This block turns a 64-bit DES key into the sixteen 48-bit round subkeys, one per round, in step with an external round datapath. When a key is loaded it is reduced to 56 bits by the PC-1 selection. The result sits in a register as two 28-bit halves, C and D. The subkey on the output is always the PC-2 selection of that register, so it is ready in the same cycle the register updates.

The direction is captured when the key is loaded. In the encrypting direction both halves rotate left before each round. In the decrypting direction a separate right-rotation path, chosen by a 2:1 multiplexer, walks the same states backwards. The subkeys therefore come out in reverse order, and no table of subkeys is stored.

The datapath pulses `step` once per round to move to the next subkey. `last` tells it when round 16 has been reached. A new `load` restarts the schedule, so the same key can be reloaded for each stage of a triple-DES pass.

Top module: `des_subkey_gen`

## Requirements
- R1: While `rst` is high and after it falls, until the first load: `ready` = 0, `round` = 0, `last` = 0 and `subkey` = 0.
- R2: Key bit numbering is DES order, with bit 1 = `key[63]` and bit 64 = `key[0]`. The parity bits `key[56]`, `key[48]`, `key[40]`, `key[32]`, `key[24]`, `key[16]`, `key[8]` and `key[0]` have no effect on any subkey. Subkey bit 1 is `subkey[47]`.
- R3: In the cycle after `load`: `ready` = 1 and `round` = 1. The output is K1 when the captured direction is encrypt, and K16 when it is decrypt.
- R4: In the encrypt direction (`decrypt` = 0 at load), round r shows K_r. K_r is the PC-2 selection after C and D have been left-rotated by the cumulative amounts 1,1,2,2,2,2,2,2,1,2,2,2,2,2,2,1. The key 133457799BBCDFF1 gives K1 = 1B02EFFC7072 and K16 = CB3D8B0E17F5.
- R5: In the decrypt direction (`decrypt` = 1 at load), round r shows K_(17-r). Round 1 uses the unrotated PC-1 value.
- R6: A `step` while `ready` is high and `round` < 16 increments `round` by one and moves to the next subkey. Without `step`, `round` and `subkey` hold.
- R7: `last` is 1 exactly when `round` = 16. A `step` at round 16 changes neither `round` nor `subkey`.
- R8: The direction is sampled only at `load`. Changing `decrypt` between loads has no effect on the sequence.
- R9: `load` takes priority over `step`. A load in the middle of a run restarts at round 1 with the new key.
- R10: A `step` while `ready` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Capture `key` and `decrypt`, and restart at round 1 |
| decrypt | input | 1 | Direction sampled at load: 1 = reverse subkey order |
| step | input | 1 | Advance to the next round |
| key | input | 64 | DES key, bit 1 at the MSB |
| subkey | output | 48 | Subkey for the current round |
| round | output | 5 | Current round index, 1 to 16 (0 before any load) |
| ready | output | 1 | A key has been loaded and `subkey` is valid |
| last | output | 1 | Round 16 reached |

## Verification
If the C/D register is corrupted, or a rotation amount is wrong, the error shows on `subkey` in the very cycle after the faulty step. The error then persists in every later round, because each state is derived from the one before it. A wrong direction path shows up at the first step after a decrypt load: the round-2 subkey differs from K15. A faulty round counter shows on `round` and `last` at once, and it also misaligns which rotation amount is applied on the following step. The bench therefore compares every round of many keys in both directions against subkeys it computes from cumulative rotations.

// File: rtl/des_subkey_gen.sv
module des_subkey_gen (
  input  logic        clk,
  input  logic        rst,
  input  logic        load,
  input  logic        decrypt,
  input  logic        step,
  input  logic [63:0] key,
  output logic [47:0] subkey,
  output logic [4:0]  round,
  output logic        ready,
  output logic        last
);
  localparam int HALF   = 28;
  localparam int KBITS  = 2 * HALF;
  localparam int SBITS  = 48;
  localparam int NROUND = 16;

  localparam int SEL1 [KBITS] = '{
    57, 49, 41, 33, 25, 17,  9,  1, 58, 50, 42, 34, 26, 18,
    10,  2, 59, 51, 43, 35, 27, 19, 11,  3, 60, 52, 44, 36,
    63, 55, 47, 39, 31, 23, 15,  7, 62, 54, 46, 38, 30, 22,
    14,  6, 61, 53, 45, 37, 29, 21, 13,  5, 28, 20, 12,  4};

  localparam int SEL2 [SBITS] = '{
    14, 17, 11, 24,  1,  5,  3, 28, 15,  6, 21, 10,
    23, 19, 12,  4, 26,  8, 16,  7, 27, 20, 13,  2,
    41, 52, 31, 37, 47, 55, 30, 40, 51, 45, 33, 48,
    44, 49, 39, 56, 34, 53, 46, 42, 50, 36, 29, 32};

  localparam logic [NROUND:1] SINGLE_AT = 16'b1000_0001_0000_0011;

  logic [HALF-1:0]  c_q, d_q;
  logic [4:0]       idx_q;
  logic             dir_q, ready_q;
  logic [KBITS-1:0] reduced;
  logic [KBITS-1:0] cd;

  wire unused_parity = ^{key[56], key[48], key[40], key[32],
                         key[24], key[16], key[8],  key[0]};

  function automatic logic [HALF-1:0] rotl(logic [HALF-1:0] x, logic two);
    return two ? {x[HALF-3:0], x[HALF-1:HALF-2]} : {x[HALF-2:0], x[HALF-1]};
  endfunction

  function automatic logic [HALF-1:0] rotr(logic [HALF-1:0] x, logic two);
    return two ? {x[1:0], x[HALF-1:2]} : {x[0], x[HALF-1:1]};
  endfunction

  always_comb begin
    reduced = '0;
    for (int i = 0; i < KBITS; i++)
      reduced[6'(KBITS-1-i)] = key[6'(64-SEL1[i])];
  end

  assign cd = {c_q, d_q};

  always_comb begin
    subkey = '0;
    for (int j = 0; j < SBITS; j++)
      subkey[6'(SBITS-1-j)] = cd[6'(KBITS-SEL2[j])];
  end

  wire [4:0] enc_sel = idx_q + 5'd1;
  wire [4:0] dec_sel = 5'd17 - idx_q;
  wire       enc_two = !SINGLE_AT[enc_sel];
  wire       dec_two = !SINGLE_AT[dec_sel];
  wire       go      = step && ready_q && (idx_q != 5'(NROUND));

  always_ff @(posedge clk) begin
    if (rst) begin
      c_q     <= '0;
      d_q     <= '0;
      idx_q   <= '0;
      dir_q   <= 1'b0;
      ready_q <= 1'b0;
    end else if (load) begin
      c_q     <= decrypt ? reduced[KBITS-1:HALF] : rotl(reduced[KBITS-1:HALF], 1'b0);
      d_q     <= decrypt ? reduced[HALF-1:0]     : rotl(reduced[HALF-1:0], 1'b0);
      idx_q   <= 5'd1;
      dir_q   <= decrypt;
      ready_q <= 1'b1;
    end else if (go) begin
      c_q   <= dir_q ? rotr(c_q, dec_two) : rotl(c_q, enc_two);
      d_q   <= dir_q ? rotr(d_q, dec_two) : rotl(d_q, enc_two);
      idx_q <= idx_q + 5'd1;
    end
  end

  assign round = idx_q;
  assign ready = ready_q;
  assign last  = (idx_q == 5'(NROUND));

  assert_load_restarts_R3: assert property (@(posedge clk) disable iff (rst)
    load |=> (round == 5'd1 && ready));

  assert_step_counts_R6: assert property (@(posedge clk) disable iff (rst)
    (step && !load && ready && round != 5'd16) |=> round == $past(round) + 5'd1);

  assert_end_holds_R7: assert property (@(posedge clk) disable iff (rst)
    (!load && round == 5'd16) |=> (round == 5'd16 && $stable(subkey)));

  assert_rotation_keeps_weight_R4: assert property (@(posedge clk) disable iff (rst)
    (!load && ready) |=> $countones({c_q, d_q}) == $past($countones({c_q, d_q})));

  assert_idle_ignores_step_R10: assert property (@(posedge clk) disable iff (rst)
    (!load && !ready) |=> (!ready && round == 5'd0 && subkey == '0));

  assert_direction_held_R8: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(dir_q));
endmodule

// File: tb/tb_des_subkey_gen.sv
`timescale 1ns/1ps
module tb_des_subkey_gen;
  logic        clk = 1'b0;
  logic        rst, load, decrypt, step;
  logic [63:0] key;
  logic [47:0] subkey;
  logic [4:0]  round;
  logic        ready, last;
  int compared = 0, mismatched = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  des_subkey_gen dut (.clk(clk), .rst(rst), .load(load), .decrypt(decrypt),
    .step(step), .key(key), .subkey(subkey), .round(round), .ready(ready), .last(last));

  localparam int T1 [56] = '{
    57, 49, 41, 33, 25, 17,  9,  1, 58, 50, 42, 34, 26, 18,
    10,  2, 59, 51, 43, 35, 27, 19, 11,  3, 60, 52, 44, 36,
    63, 55, 47, 39, 31, 23, 15,  7, 62, 54, 46, 38, 30, 22,
    14,  6, 61, 53, 45, 37, 29, 21, 13,  5, 28, 20, 12,  4};
  localparam int T2 [48] = '{
    14, 17, 11, 24,  1,  5,  3, 28, 15,  6, 21, 10,
    23, 19, 12,  4, 26,  8, 16,  7, 27, 20, 13,  2,
    41, 52, 31, 37, 47, 55, 30, 40, 51, 45, 33, 48,
    44, 49, 39, 56, 34, 53, 46, 42, 50, 36, 29, 32};

  function automatic logic [47:0] expect_k(logic [63:0] k, int n);
    logic [55:0] v;
    logic [27:0] c, d;
    logic [47:0] o;
    int total = 0;
    for (int i = 1; i <= 56; i++) v[56-i] = k[64-T1[i-1]];
    c = v[55:28]; d = v[27:0];
    for (int r = 1; r <= n; r++) total += (r == 1 || r == 2 || r == 9 || r == 16) ? 1 : 2;
    for (int s = 0; s < total; s++) begin
      c = {c[26:0], c[27]};
      d = {d[26:0], d[27]};
    end
    v = {c, d};
    for (int j = 1; j <= 48; j++) o[48-j] = v[56-T2[j-1]];
    return o;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_load(logic [63:0] k, logic dir);
    @(negedge clk); key = k; decrypt = dir; load = 1'b1;
    @(negedge clk); load = 1'b0;
  endtask

  task automatic do_step();
    @(negedge clk); step = 1'b1;
    @(negedge clk); step = 1'b0;
  endtask

  task automatic run_key(logic [63:0] k, logic dir);
    do_load(k, dir);
    for (int r = 1; r <= 16; r++) begin
      if (r > 1) do_step();
      check(dir ? "R5 subkey" : "R4 subkey", 64'(subkey), 64'(expect_k(k, dir ? 17 - r : r)));
      check("R6 round", 64'(round), 64'(r));
      check("R7 last", 64'(last), 64'(r == 16));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [63:0] k;
    logic [47:0] held;
    rst = 1'b1; load = 1'b0; decrypt = 1'b0; step = 1'b0; key = '0;
    repeat (3) @(negedge clk);
    check("R1 ready in reset", 64'(ready), 64'd0);
    check("R1 round in reset", 64'(round), 64'd0);
    check("R1 subkey in reset", 64'(subkey), 64'd0);
    @(negedge clk); rst = 1'b0;
    do_step();
    check("R10 ready after idle step", 64'(ready), 64'd0);
    check("R10 round after idle step", 64'(round), 64'd0);
    check("R1 last idle", 64'(last), 64'd0);

    do_load(64'h133457799BBCDFF1, 1'b0);
    check("R3 ready after load", 64'(ready), 64'd1);
    check("R4 known K1", 64'(subkey), 64'h1B02EFFC7072);
    repeat (15) do_step();
    check("R4 known K16", 64'(subkey), 64'hCB3D8B0E17F5);
    do_load(64'h133457799BBCDFF1, 1'b1);
    check("R3 decrypt first is K16", 64'(subkey), 64'hCB3D8B0E17F5);

    for (int i = 0; i < 10; i++) begin
      k = {32'h9E3779B9 * (i + 1), 32'h85EBCA6B ^ (32'hC2B2AE35 * i)};
      run_key(k, 1'b0);
      run_key(k, 1'b1);
    end

    k = 64'h0123456789ABCDEF;
    do_load(k, 1'b0);
    do_step();
    held = subkey;
    repeat (3) @(negedge clk);
    check("R6 hold subkey", 64'(subkey), 64'(held));
    check("R6 hold round", 64'(round), 64'd2);

    repeat (14) do_step();
    check("R7 last at 16", 64'(last), 64'd1);
    held = subkey;
    do_step();
    check("R7 round stays 16", 64'(round), 64'd16);
    check("R7 subkey stays", 64'(subkey), 64'(held));

    do_load(k, 1'b0);
    @(negedge clk); decrypt = 1'b1;
    for (int r = 2; r <= 5; r++) begin
      do_step();
      check("R8 direction latched", 64'(subkey), 64'(expect_k(k, r)));
    end
    decrypt = 1'b0;

    @(negedge clk); key = 64'hFEDCBA9876543210; decrypt = 1'b0; load = 1'b1; step = 1'b1;
    @(negedge clk); load = 1'b0; step = 1'b0;
    check("R9 load beats step round", 64'(round), 64'd1);
    check("R9 reload new key", 64'(subkey), 64'(expect_k(64'hFEDCBA9876543210, 1)));

    k = 64'hA5C3_5A3C_0F1E_2D4B;
    do_load(k ^ 64'h0101010101010101, 1'b0);
    check("R2 parity ignored K1", 64'(subkey), 64'(expect_k(k, 1)));
    do_load(k ^ 64'h0101010101010101, 1'b1);
    check("R2 parity ignored K16", 64'(subkey), 64'(expect_k(k, 16)));

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule